// File: doc/BRIEF.md
# Critical Control Line Debounce and Far-End Drive

This block conditions two slow, critical control lines before a serial link carries them, and drives the matching pair of outputs at the far end. A prescaler running on the crystal clock makes a single-cycle sample strobe. Its period is one of two ratios, picked by a rate-select input: a standard rate and a half rate. On each strobe every control line is sampled into its own agreement filter. The filtered level moves only after the line has shown the same value on four strobes in a row. Noise, glitches and short pulses therefore never reach the link.

The filtered bits go out as plain levels for the link framer. At the receiving end the block takes the two bits recovered from the link and passes them to its outputs. When the lock-loss flag is raised, both outputs are pinned high whatever was received. All control and status pins are plain levels with no handshake. The filtered bits are ordinary registered state that the framer may read on any cycle, so there is no back-pressure to honour.

Top module: `ctl_sense_filter`

## Requirements
- R1: With `dbl_mode` low, the sample strobe fires on exactly one cycle out of every STD_DIV clock cycles (default 18,432), counted from the last restart of the prescaler.
- R2: With `dbl_mode` high, the sample strobe fires on exactly one cycle out of every DBL_DIV clock cycles (default 36,864).
- R3: `ctl_filt[i]` takes a new level on the clock edge of the strobe that completes four consecutive samples of `ctl_in[i]` at that level, and changes at no other edge.
- R4: A level on `ctl_in[i]` that is present for fewer than four consecutive samples leaves `ctl_filt[i]` unchanged.
- R5: After reset, `ctl_filt` is all ones and every sample history holds ones, so a low needs four fresh low samples before it is accepted.
- R6: Any edge at which `dbl_mode` differs from the rate the prescaler last ran at restarts the prescaler count at zero with no strobe on that cycle. The rate held in reset is standard. The next strobe then comes a full period of the new rate later.
- R7: The two channels are independent: activity on one input never alters the filtered value of the other.
- R8: While `unlock` is 1, `ctl_out` is all ones regardless of `rx_ctl`.
- R9: While `unlock` is 0, `ctl_out` equals `rx_ctl` in the same cycle (combinational path).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbl_mode | input | 1 | Rate select: 0 = standard divide, 1 = double divide |
| ctl_in | input | NUM_CH (2) | Raw control lines, synchronous to `clk` |
| ctl_filt | output | NUM_CH (2) | Filtered control bits for the link framer |
| rx_ctl | input | NUM_CH (2) | Control bits recovered from the link |
| unlock | input | 1 | Link out of lock when 1 |
| ctl_out | output | NUM_CH (2) | Far-end control outputs |

## Verification
On every cycle the assertions check several things. The prescaler count stays below the period of the active rate. The strobe never fires on two cycles in a row. A rate change clears the count. The filtered bit holds steady between strobes, and when it moves it takes the value of the newest sample. The outputs are all high while the link is out of lock. Other behaviour can only be shown by the bench's scenarios, where a cycle-accurate reference model follows the same inputs: the exact strobe spacing at both rates, the four-sample acceptance point, the rejection of short pulses, the independence of the channels and the restart timing after rate changes in the middle of a count.

// File: rtl/ctl_filt_pkg.sv
package ctl_filt_pkg;
  typedef enum logic {
    RATE_STD = 1'b0,
    RATE_DBL = 1'b1
  } rate_e;
endpackage

// File: rtl/ctl_rate_prescaler.sv
module ctl_rate_prescaler
  import ctl_filt_pkg::*;
#(
  parameter int STD_DIV = 18432,
  parameter int DBL_DIV = 36864
) (
  input  logic  clk,
  input  logic  rst_n,
  input  rate_e rate,
  output logic  stb
);
  localparam int MAX_DIV = (DBL_DIV > STD_DIV) ? DBL_DIV : STD_DIV;
  localparam int CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  rate_e            rate_q;
  logic             rate_same;

  always_comb begin
    last_cnt  = (rate_q == RATE_DBL) ? CNT_W'(DBL_DIV - 1) : CNT_W'(STD_DIV - 1);
    rate_same = (rate == rate_q);
    stb       = rate_same && (cnt_q == last_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rate_q <= RATE_STD;
    end else if (!rate_same) begin
      cnt_q  <= '0;
      rate_q <= rate;
    end else if (stb) begin
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R1 / R2: the count never passes the period of the active rate
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == RATE_DBL) ? (cnt_q < CNT_W'(DBL_DIV)) : (cnt_q < CNT_W'(STD_DIV)));

  // R1: strobe is a single-cycle pulse
  assert_stb_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);

  // R6: a rate change restarts the count
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate != rate_q) |=> (cnt_q == '0));
endmodule

// File: rtl/ctl_agree_filter.sv
module ctl_agree_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic din,
  output logic filt
);
  logic [LEN-1:0] hist_q;
  logic [LEN-1:0] hist_nxt;
  logic           filt_q;

  assign hist_nxt = {hist_q[LEN-2:0], din};
  assign filt     = filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '1;
      filt_q <= 1'b1;
    end else if (stb) begin
      hist_q <= hist_nxt;
      if (&hist_nxt)       filt_q <= 1'b1;
      else if (~|hist_nxt) filt_q <= 1'b0;
    end
  end

  // R4: no change between strobes
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(filt_q));

  // R3: a change always lands on the newest sample's value
  assert_agree_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> (filt_q == hist_q[0]));
endmodule

// File: rtl/ctl_lock_gate.sv
module ctl_lock_gate #(
  parameter int NUM_CH = 2
) (
  input  logic              unlock,
  input  logic [NUM_CH-1:0] rx_bits,
  output logic [NUM_CH-1:0] out_bits
);
  always_comb begin
    out_bits = unlock ? {NUM_CH{1'b1}} : rx_bits;
  end
endmodule

// File: rtl/ctl_sense_filter.sv
module ctl_sense_filter
  import ctl_filt_pkg::*;
#(
  parameter int STD_DIV = 18432,
  parameter int DBL_DIV = 36864,
  parameter int NUM_CH  = 2,
  parameter int FLT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbl_mode,
  input  logic [NUM_CH-1:0] ctl_in,
  output logic [NUM_CH-1:0] ctl_filt,
  input  logic [NUM_CH-1:0] rx_ctl,
  input  logic              unlock,
  output logic [NUM_CH-1:0] ctl_out
);
  logic  sample_stb;
  rate_e rate_sel;

  assign rate_sel = rate_e'(dbl_mode);

  ctl_rate_prescaler #(
    .STD_DIV(STD_DIV),
    .DBL_DIV(DBL_DIV)
  ) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .rate (rate_sel),
    .stb  (sample_stb)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    ctl_agree_filter #(
      .LEN(FLT_LEN)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .stb  (sample_stb),
      .din  (ctl_in[ch]),
      .filt (ctl_filt[ch])
    );
  end

  ctl_lock_gate #(
    .NUM_CH(NUM_CH)
  ) u_gate (
    .unlock  (unlock),
    .rx_bits (rx_ctl),
    .out_bits(ctl_out)
  );

  // R8: out of lock forces every far-end output high
  assert_unlock_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |-> (&ctl_out));
endmodule

// File: tb/ctl_sense_filter_bench.sv
module ctl_sense_filter_bench;
  localparam int STD_D = 6;
  localparam int DBL_D = 11;
  localparam int NCH   = 2;
  localparam int LEN   = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           dbl_mode = 1'b0;
  logic [NCH-1:0] ctl_in = '1;
  logic [NCH-1:0] ctl_filt;
  logic [NCH-1:0] rx_ctl = '0;
  logic           unlock = 1'b1;
  logic [NCH-1:0] ctl_out;

  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  string cur_req = "R5";

  always #4 clk = ~clk;

  ctl_sense_filter #(
    .STD_DIV(STD_D), .DBL_DIV(DBL_D), .NUM_CH(NCH), .FLT_LEN(LEN)
  ) u_ctl_sense_filter (
    .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode), .ctl_in(ctl_in),
    .ctl_filt(ctl_filt), .rx_ctl(rx_ctl), .unlock(unlock), .ctl_out(ctl_out)
  );

  // behavioural reference: run-length tracking per channel
  int m_cnt;
  bit m_mode;
  bit m_last [NCH];
  int m_run  [NCH];
  bit m_out  [NCH];

  always @(posedge clk) begin
    bit fire;
    if (!rst_n) begin
      m_cnt  = 0;
      m_mode = 0;
      for (int c = 0; c < NCH; c++) begin
        m_last[c] = 1; m_run[c] = LEN; m_out[c] = 1;
      end
    end else begin
      fire = 0;
      if (dbl_mode != m_mode) begin
        m_cnt = 0; m_mode = dbl_mode;
      end else if (m_cnt == (m_mode ? DBL_D : STD_D) - 1) begin
        fire = 1; m_cnt = 0;
      end else begin
        m_cnt++;
      end
      if (fire) begin
        for (int c = 0; c < NCH; c++) begin
          if (ctl_in[c] == m_last[c]) m_run[c]++;
          else begin m_last[c] = ctl_in[c]; m_run[c] = 1; end
          if (m_run[c] >= LEN) m_out[c] = m_last[c];
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    logic [NCH-1:0] exp_f, exp_o;
    #1;
    for (int c = 0; c < NCH; c++) exp_f[c] = m_out[c];
    exp_o = unlock ? {NCH{1'b1}} : rx_ctl;
    total++;
    if (ctl_filt !== exp_f) begin
      bad++;
      $display("FAIL %s ctl_filt actual=%b expected=%b t=%0t", cur_req, ctl_filt, exp_f, $time);
    end
    total++;
    if (ctl_out !== exp_o) begin
      bad++;
      $display("FAIL %s ctl_out actual=%b expected=%b t=%0t", unlock ? "R8" : "R9",
               ctl_out, exp_o, $time);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R5: reset state, then a low needs four fresh samples
    cur_req = "R5";
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    total++;
    if (ctl_filt !== 2'b11) begin
      bad++;
      $display("FAIL R5 reset actual=%b expected=11", ctl_filt);
    end
    // R1 / R3: ch0 low for many samples at standard rate
    cur_req = "R3";
    ctl_in = 2'b10;
    cyc(STD_D * 6);
    total++;
    if (ctl_filt[0] !== 1'b0) begin
      bad++;
      $display("FAIL R3 ch0 actual=%b expected=0", ctl_filt[0]);
    end
    cur_req = "R1";
    ctl_in = 2'b11;
    cyc(STD_D * 6);
    // R4: short pulses on ch1
    cur_req = "R4";
    ctl_in = 2'b01;
    cyc(STD_D * 2);
    ctl_in = 2'b11;
    cyc(STD_D * 3);
    ctl_in = 2'b01;
    cyc(STD_D * 3 - 1);
    ctl_in = 2'b11;
    cyc(STD_D * 2);
    total++;
    if (ctl_filt[1] !== 1'b1) begin
      bad++;
      $display("FAIL R4 ch1 actual=%b expected=1", ctl_filt[1]);
    end
    // R7: opposite activity on the two channels
    cur_req = "R7";
    ctl_in = 2'b01;
    cyc(STD_D * 5);
    ctl_in = 2'b10;
    cyc(STD_D * 5);
    for (int k = 0; k < 8; k++) begin
      ctl_in[0] = ~ctl_in[0];
      cyc(STD_D);
    end
    cyc(STD_D * 5);
    // R2: double rate
    cur_req = "R2";
    dbl_mode = 1'b1;
    ctl_in = 2'b00;
    cyc(DBL_D * 6);
    ctl_in = 2'b11;
    cyc(DBL_D * 3);
    ctl_in = 2'b01;
    cyc(DBL_D * 6);
    // R6: rate toggles mid-count
    cur_req = "R6";
    for (int k = 0; k < 10; k++) begin
      cyc(3 + k);
      dbl_mode = ~dbl_mode;
      ctl_in = ctl_in ^ 2'b11;
      cyc(STD_D * 4 + k);
    end
    dbl_mode = 1'b0;
    cyc(2);
    dbl_mode = 1'b1;
    cyc(1);
    dbl_mode = 1'b0;
    cyc(STD_D * 5);
    // R8 / R9: lock gating
    cur_req = "R9";
    unlock = 1'b0;
    for (int k = 0; k < 8; k++) begin
      rx_ctl = NCH'(k);
      cyc(1);
      unlock = k[2];
      cyc(1);
      unlock = 1'b0;
    end
    cur_req = "R8";
    unlock = 1'b1;
    rx_ctl = 2'b00;
    cyc(3);
    total++;
    if (ctl_out !== 2'b11) begin
      bad++;
      $display("FAIL R8 ctl_out actual=%b expected=11", ctl_out);
    end
    unlock = 1'b0;
    cyc(1);
    total++;
    if (ctl_out !== 2'b00) begin
      bad++;
      $display("FAIL R9 ctl_out actual=%b expected=00", ctl_out);
    end
    cyc(2);
    finish_run();
  end
endmodule